// File: doc/BRIEF.md
# Transmit-Complete Flag and Interrupt Block

This block keeps one completion flag for each message buffer of a CAN-style controller. When the transmit engine reports that a buffer has finished sending, the flag for that buffer is set. Software acknowledges a completion by writing a zero to the flag. Writing a one leaves the flag as it is. A fresh transmit request for the same buffer also clears its flag. A second register holds one interrupt-enable bit per buffer. A single registered interrupt line is raised while any buffer has both its flag and its enable bit set.

Software reaches both registers over a small byte-addressed register bus with one byte-enable per byte lane. Read data is registered. A read can be marked as the read half of a read-modify-write. On such a read the flag register returns all ones, so the write-back that follows cannot clear a flag that software never meant to touch. The request register is outside this block and appears only as per-buffer strobe inputs.

Top module: `txc_regs`

## Requirements
- R1: Reset (synchronous, active high) clears all flags, all enable bits, the interrupt output and the read data to 0.
- R2: A high `tx_done[x]` in a cycle sets flag x at the next clock edge.
- R3: A write to the flag register clears flag x when bit x of the write data is 0 and its byte lane is enabled. A write data bit of 1, or a disabled lane, leaves the flag unchanged. `bus_be[0]` covers bits 7:0 and `bus_be[1]` covers bits 15:8.
- R4: A high `req_wr[x]` clears flag x at the next clock edge.
- R5: When `tx_done[x]` and a clearing cause (a software zero-write or `req_wr[x]`) fall in the same cycle, flag x ends up set to 1.
- R6: A read of the flag register with `bus_rmw` high returns 16'hFFFF. With `bus_rmw` low it returns the true flag values.
- R7: The enable register reads back exactly what was written. Each byte lane is written only when its `bus_be` bit is high.
- R8: `tx_irq` is a register loaded from the OR of (flags AND enables). It goes high one edge after the AND becomes nonzero and goes low one edge after the AND becomes zero.
- R9: The register is selected by byte address bits [3:1]: word 0 (byte addresses 0 and 1) is the flag register and word 1 (byte addresses 2 and 3) is the enable register. `bus_addr[0]` is ignored. Reads of any other word return 0, and writes to any other word change nothing.
- R10: `bus_rdata` is loaded at the clock edge that ends a read cycle and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks a read as the read half of a read-modify-write |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tx_done | input | 16 | Per-buffer transmit-complete pulses |
| req_wr | input | 16 | Per-buffer strobes for a transmit request being written with 1 |
| tx_irq | output | 1 | Combined transmit interrupt, level |

## Verification
A completion pulse from the transmit engine can land in the same cycle as a software clear of the same flag, or in the same cycle as a request strobe for that buffer. The stimulus table includes a step where `tx_done` and a zero-write to the same bit are driven in the same clock cycle. The bench then reads the flag register back and expects that bit to be set while the other cleared bits stay cleared. The clocked checks compare each flag against the causes present in the previous cycle, with the set taking priority.

// File: rtl/txc_pkg.sv
package txc_pkg;

  // Word indexes on the register bus (byte address >> 1)
  localparam int unsigned FLAG_WORD = 0;
  localparam int unsigned EN_WORD   = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_EN   = 2'd2
  } txc_sel_e;

endpackage

// File: rtl/txc_bus_if.sv
module txc_bus_if #(
  parameter int unsigned NUM_BUF = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic               rd,
  input  logic               rmw,
  input  logic [NUM_BUF/8-1:0] be,
  input  logic [NUM_BUF-1:0] wdata,
  input  logic [NUM_BUF-1:0] flags,
  input  logic [NUM_BUF-1:0] enables,
  output logic [NUM_BUF-1:0] flag_clr,
  output logic [NUM_BUF-1:0] en_we,
  output logic [NUM_BUF-1:0] rdata
);
  import txc_pkg::*;

  localparam int unsigned LANES = NUM_BUF / 8;
  localparam int unsigned WA_W  = ADDR_W - 1;

  logic [WA_W-1:0]    word_idx;
  logic               unused_byte_sel;
  txc_sel_e           sel;
  logic [NUM_BUF-1:0] lane_mask;
  logic [NUM_BUF-1:0] rdata_q;

  assign word_idx        = addr[ADDR_W-1:1];
  assign unused_byte_sel = addr[0];

  always_comb begin
    if (word_idx == WA_W'(FLAG_WORD))
      sel = SEL_FLAG;
    else if (word_idx == WA_W'(EN_WORD))
      sel = SEL_EN;
    else
      sel = SEL_NONE;
  end

  // Expand byte enables to a per-bit mask
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*8 +: 8] = {8{be[l]}};
  end

  always_comb begin
    flag_clr = '0;
    en_we    = '0;
    if (wr && sel == SEL_FLAG)
      flag_clr = lane_mask & ~wdata;
    if (wr && sel == SEL_EN)
      en_we = lane_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      unique case (sel)
        SEL_FLAG: rdata_q <= rmw ? '1 : flags;
        SEL_EN:   rdata_q <= enables;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/txc_flag_bank.sv
module txc_flag_bank #(
  parameter int unsigned NUM_BUF = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] set_i,
  input  logic [NUM_BUF-1:0] sw_clr_i,
  input  logic [NUM_BUF-1:0] req_clr_i,
  output logic [NUM_BUF-1:0] flags_o
);

  logic [NUM_BUF-1:0] flag_q;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_q[b] <= 1'b0;
      else if (set_i[b])
        flag_q[b] <= 1'b1;          // completion wins over any clear
      else if (sw_clr_i[b] || req_clr_i[b])
        flag_q[b] <= 1'b0;
    end
  end

  assign flags_o = flag_q;

endmodule

// File: rtl/txc_enable_reg.sv
module txc_enable_reg #(
  parameter int unsigned NUM_BUF = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] we_mask,
  input  logic [NUM_BUF-1:0] wdata,
  output logic [NUM_BUF-1:0] en_o
);

  logic [NUM_BUF-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else
      en_q <= (en_q & ~we_mask) | (wdata & we_mask);
  end

  assign en_o = en_q;

endmodule

// File: rtl/txc_irq_gen.sv
module txc_irq_gen #(
  parameter int unsigned NUM_BUF = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] flags,
  input  logic [NUM_BUF-1:0] enables,
  output logic               irq
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst)
      irq_q <= 1'b0;
    else
      irq_q <= |(flags & enables);
  end

  assign irq = irq_q;

endmodule

// File: rtl/txc_regs.sv
module txc_regs #(
  parameter int unsigned NUM_BUF = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_rmw,
  input  logic [NUM_BUF/8-1:0] bus_be,
  input  logic [NUM_BUF-1:0]   bus_wdata,
  output logic [NUM_BUF-1:0]   bus_rdata,
  input  logic [NUM_BUF-1:0]   tx_done,
  input  logic [NUM_BUF-1:0]   req_wr,
  output logic                 tx_irq
);

  logic [NUM_BUF-1:0] flags_q;
  logic [NUM_BUF-1:0] en_q;
  logic [NUM_BUF-1:0] flag_clr;
  logic [NUM_BUF-1:0] en_we;

  txc_bus_if #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .rmw      (bus_rmw),
    .be       (bus_be),
    .wdata    (bus_wdata),
    .flags    (flags_q),
    .enables  (en_q),
    .flag_clr (flag_clr),
    .en_we    (en_we),
    .rdata    (bus_rdata)
  );

  txc_flag_bank #(.NUM_BUF(NUM_BUF)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_i     (tx_done),
    .sw_clr_i  (flag_clr),
    .req_clr_i (req_wr),
    .flags_o   (flags_q)
  );

  txc_enable_reg #(.NUM_BUF(NUM_BUF)) u_en (
    .clk     (clk),
    .rst     (rst),
    .we_mask (en_we),
    .wdata   (bus_wdata),
    .en_o    (en_q)
  );

  txc_irq_gen #(.NUM_BUF(NUM_BUF)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .flags   (flags_q),
    .enables (en_q),
    .irq     (tx_irq)
  );

endmodule

// File: rtl/txc_regs_chk.sv
module txc_regs_chk #(
  parameter int unsigned NUM_BUF = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic                 bus_rmw,
  input logic [NUM_BUF/8-1:0] bus_be,
  input logic [NUM_BUF-1:0]   bus_wdata,
  input logic [NUM_BUF-1:0]   bus_rdata,
  input logic [NUM_BUF-1:0]   tx_done,
  input logic [NUM_BUF-1:0]   req_wr,
  input logic                 tx_irq,
  input logic [NUM_BUF-1:0]   flags,
  input logic [NUM_BUF-1:0]   enables
);

  localparam int unsigned WA_W = ADDR_W - 1;

  logic               flag_addr;
  logic [NUM_BUF-1:0] be_bits;
  logic [NUM_BUF-1:0] clr_cause;

  assign flag_addr = (bus_addr[ADDR_W-1:1] == WA_W'(txc_pkg::FLAG_WORD));

  for (genvar l = 0; l < NUM_BUF/8; l++) begin : g_be
    assign be_bits[l*8 +: 8] = {8{bus_be[l]}};
  end

  assign clr_cause = req_wr | ((bus_wr && flag_addr) ? (be_bits & ~bus_wdata) : '0);

  // R1: reset clears state and outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flags == '0 && enables == '0 && !tx_irq && bus_rdata == '0));

  // R2 and R5: completion sets the flag whatever else happens
  a_r2_done_sets: assert property (@(posedge clk) disable iff (rst)
    (|tx_done) |=> ((flags & $past(tx_done)) == $past(tx_done)));

  // R3: a flag only falls when a clearing cause was present
  a_r3_clear_needs_cause: assert property (@(posedge clk) disable iff (rst)
    (|flags) |=> ((($past(flags) & ~flags) & ~$past(clr_cause)) == '0));

  // R4: request strobe clears unless a completion coincides
  a_r4_req_clears: assert property (@(posedge clk) disable iff (rst)
    (|(req_wr & ~tx_done)) |=> ((flags & $past(req_wr & ~tx_done)) == '0));

  // R6: read-modify-write read of the flag register returns all ones
  a_r6_rmw_ones: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_rmw && flag_addr) |=> (bus_rdata == '1));

  // R8: interrupt follows flags AND enables one edge later
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (|(flags & enables)) |=> tx_irq);

  a_r8_irq_fall: assert property (@(posedge clk) disable iff (rst)
    (!(|(flags & enables))) |=> !tx_irq);

  // R10: read data holds while no read is issued
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd) |=> $stable(bus_rdata));

endmodule

bind txc_regs txc_regs_chk #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rmw   (bus_rmw),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .tx_done   (tx_done),
  .req_wr    (req_wr),
  .tx_irq    (tx_irq),
  .flags     (flags_q),
  .enables   (en_q)
);

// File: tb/tb_txc_regs.sv
`timescale 1ns/1ps
module tb_txc_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_rmw = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] tx_done = '0;
  logic [15:0] req_wr = '0;
  logic        tx_irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  txc_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rmw(bus_rmw), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_done(tx_done), .req_wr(req_wr), .tx_irq(tx_irq)
  );

  // Step layout: done[67:52] req[51:36] wr[35] be[34:33] wdata[32:17] exp_flags[16:1] exp_irq[0]
  // Enables are 16'h0F0F during the table.
  localparam logic [67:0] VEC [0:12] = '{
    {16'h0001, 16'h0000, 1'b0, 2'b00, 16'h0000, 16'h0001, 1'b1},  // R2
    {16'h8010, 16'h0000, 1'b0, 2'b00, 16'h0000, 16'h8011, 1'b1},  // R2
    {16'h0000, 16'h0000, 1'b1, 2'b01, 16'hFFFE, 16'h8010, 1'b0},  // R3 low lane
    {16'h0000, 16'h0000, 1'b1, 2'b10, 16'h0000, 16'h0010, 1'b0},  // R3 high lane
    {16'h0100, 16'h0000, 1'b1, 2'b11, 16'hFEFF, 16'h0110, 1'b1},  // R5 set wins
    {16'h0000, 16'h0010, 1'b0, 2'b00, 16'h0000, 16'h0100, 1'b1},  // R4
    {16'h0000, 16'h0000, 1'b1, 2'b11, 16'hFFFF, 16'h0100, 1'b1},  // R3 ones ignored
    {16'h0202, 16'h0000, 1'b0, 2'b00, 16'h0000, 16'h0302, 1'b1},  // R2
    {16'h0000, 16'h0000, 1'b1, 2'b11, 16'h0000, 16'h0000, 1'b0},  // R3 clear all
    {16'hFFFF, 16'h0000, 1'b0, 2'b00, 16'h0000, 16'hFFFF, 1'b1},  // R2
    {16'h0000, 16'h0000, 1'b1, 2'b01, 16'h00AA, 16'hFFAA, 1'b1},  // R3 low lane only
    {16'h0000, 16'hFF00, 1'b0, 2'b00, 16'h0000, 16'h00AA, 1'b1},  // R4
    {16'h0000, 16'h0000, 1'b1, 2'b11, 16'hFFF5, 16'h00A0, 1'b0}   // R3 R8
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one bus cycle from a negedge, return at the next negedge with inputs idle
  task automatic cyc(input logic [3:0] a, input logic wr, input logic rd, input logic rmw,
                     input logic [1:0] be, input logic [15:0] wd,
                     input logic [15:0] dn, input logic [15:0] rq);
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_rmw = rmw;
    bus_be = be; bus_wdata = wd; tx_done = dn; req_wr = rq;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_rmw = 1'b0; bus_be = '0;
    bus_wdata = '0; tx_done = '0; req_wr = '0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic rmw, output logic [15:0] d);
    cyc(a, 1'b0, 1'b1, rmw, 2'b00, 16'h0, 16'h0, 16'h0);
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 irq in reset", {15'h0, tx_irq}, 16'h0);
    check("R1 rdata in reset", bus_rdata, 16'h0);
    rst = 1'b0;
    rd_reg(4'd0, 1'b0, d); check("R1 flags after reset", d, 16'h0000);
    rd_reg(4'd2, 1'b0, d); check("R1 enables after reset", d, 16'h0000);

    cyc(4'd2, 1'b1, 1'b0, 1'b0, 2'b11, 16'h0F0F, 16'h0, 16'h0);

    for (int i = 0; i < 13; i++) begin
      logic [67:0] v;
      v = VEC[i];
      cyc(4'd0, v[35], 1'b0, 1'b0, v[34:33], v[32:17], v[67:52], v[51:36]);
      rd_reg(4'd0, 1'b0, d);
      check($sformatf("R2-R5 table step %0d flags", i), d, v[16:1]);
      check($sformatf("R8 table step %0d irq", i), {15'h0, tx_irq}, {15'h0, v[0]});
    end

    // R6: read-modify-write view versus plain view
    rd_reg(4'd0, 1'b1, d); check("R6 rmw read", d, 16'hFFFF);
    rd_reg(4'd0, 1'b0, d); check("R6 plain read", d, 16'h00A0);
    // R3: write-back of the rmw value keeps flags
    cyc(4'd0, 1'b1, 1'b0, 1'b0, 2'b11, 16'hFFFF, 16'h0, 16'h0);
    rd_reg(4'd0, 1'b0, d); check("R3 rmw write-back", d, 16'h00A0);

    // R7: enable readback and byte lanes
    cyc(4'd2, 1'b1, 1'b0, 1'b0, 2'b11, 16'h5A3C, 16'h0, 16'h0);
    rd_reg(4'd2, 1'b0, d); check("R7 enable readback", d, 16'h5A3C);
    check("R8 irq via enable", {15'h0, tx_irq}, 16'h0001);
    cyc(4'd3, 1'b1, 1'b0, 1'b0, 2'b10, 16'hFFFF, 16'h0, 16'h0);
    rd_reg(4'd2, 1'b0, d); check("R7 high lane only", d, 16'hFF3C);

    // R8: one-edge latency on the falling side
    cyc(4'd2, 1'b1, 1'b0, 1'b0, 2'b11, 16'h0000, 16'h0, 16'h0);
    check("R8 irq still high", {15'h0, tx_irq}, 16'h0001);
    @(negedge clk);
    check("R8 irq low", {15'h0, tx_irq}, 16'h0000);

    // R9: address decode
    cyc(4'd4, 1'b1, 1'b0, 1'b0, 2'b11, 16'h0000, 16'h0, 16'h0);
    rd_reg(4'd4, 1'b0, d); check("R9 unmapped read", d, 16'h0000);
    rd_reg(4'd1, 1'b0, d); check("R9 odd address flags", d, 16'h00A0);
    rd_reg(4'd2, 1'b0, d); check("R9 enables untouched", d, 16'h0000);

    // R10: read data changes only at the edge ending the read
    bus_addr = 4'd0; bus_rd = 1'b1;
    #1;
    check("R10 rdata before edge", bus_rdata, 16'h0000);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R10 rdata after edge", bus_rdata, 16'h00A0);
    @(negedge clk);
    check("R10 rdata held", bus_rdata, 16'h00A0);

    // R1: reset in mid-run
    cyc(4'd2, 1'b1, 1'b0, 1'b0, 2'b11, 16'hFFFF, 16'h0, 16'h0);
    @(negedge clk);
    check("R8 irq before reset", {15'h0, tx_irq}, 16'h0001);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 irq mid-run reset", {15'h0, tx_irq}, 16'h0000);
    rst = 1'b0;
    rd_reg(4'd0, 1'b0, d); check("R1 flags mid-run reset", d, 16'h0000);
    rd_reg(4'd2, 1'b0, d); check("R1 enables mid-run reset", d, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule